// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of memory requests, one per cycle, each carrying a byte address and the element indices it belongs to. A start pulse captures the operands: base address, element distance, vector length, access mode, a vector of signed offsets and an element mask. The sequencer then presents requests on a valid/ready handshake until the access is complete, and marks the end with a one-cycle done pulse. Data movement and caching are left to the surrounding memory pipeline.

Four access patterns share one walker. Strided access steps the address by a fixed distance of 8-byte words. Indexed access adds a per-element signed offset to the base, which gives gather and scatter. Compressed access visits only the elements whose mask bit is set. It reports both the element's register-side position and a separate packed memory position, so selected elements land in consecutive memory slots. Mask-register access moves a one-bit-per-element mask, one byte per request, using the same distance rule.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `req_valid`, `done` and `busy` are low until a start is accepted.
- R2: `start` is accepted only while `busy` is low; it captures all operands and raises `busy`. A `start` pulse while `busy` is high has no effect on the request stream under way.
- R3: Mode encoding on `mode`: 0 strided, 1 indexed, 2 compressed, 3 mask-register. In strided mode request n has `req_addr` = base + n*stride*8 (modulo 2^AW), and `req_elem` = `req_pidx` = n, for n = 0 .. length-1.
- R4: In indexed mode request n has `req_addr` = base + sign-extended offset n, where offset n sits at bits [n*OW +: OW] of `offsets`; `req_elem` = `req_pidx` = n.
- R5: In compressed mode only elements i below the length with mask bit i set are requested, in ascending i; the k-th such request has `req_elem` = i, `req_pidx` = k and `req_addr` = base + k*stride*8.
- R6: In mask-register mode ceil(length/8) requests are made; request j has `req_addr` = base + j*stride*8 and `req_elem` = `req_pidx` = j.
- R7: The effective length is `vlen` clamped to MAXVL; a length of 0 issues no request.
- R8: A request is consumed only when `req_valid` and `req_ready` are both high; while `req_ready` is low, `req_valid` stays high and `req_addr`, `req_elem` and `req_pidx` hold.
- R9: `done` is high for exactly one cycle: the cycle after the final handshake, or the cycle after start when there is no request (zero length, or compressed with no selected element); `busy` falls at the end of that cycle.
- R10: With `req_ready` held high, requests come on consecutive cycles with no bubble, including across skipped elements in compressed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an access (taken only when idle) |
| mode | input | 2 | Access pattern: 0 strided, 1 indexed, 2 compressed, 3 mask-register |
| base | input | AW | Base byte address |
| stride | input | AW | Element distance in 8-byte words |
| vlen | input | LW | Number of elements, clamped to MAXVL |
| offsets | input | MAXVL*OW | Packed signed per-element byte offsets |
| mask | input | MAXVL | Element select mask for compressed mode |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | AW | Request byte address |
| req_elem | output | LW | Register-side element index (byte index in mask mode) |
| req_pidx | output | LW | Memory-side packed index |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench goes after the length edges (zero, one, exactly MAXVL and above MAXVL), where a missing clamp would run past the operand vectors and an off-by-one would drop or add a final request. Compressed mode is swept over empty, full and scattered masks: a design that advanced the memory address on skipped elements would leave holes in the packed addresses, and one that scanned one element per cycle would show bubbles. Irregular ready stalls catch an address that moves before acceptance, and done timing is checked against the final handshake so that a late, early or lingering pulse is seen, as is a start pulse that wrongly restarts a busy sequencer.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int MAXVL = 16,
  parameter int LW    = $clog2(MAXVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        stride,
  input  logic [LW-1:0]        vlen,
  input  logic [MAXVL*OW-1:0]  offsets,
  input  logic [MAXVL-1:0]     mask,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [AW-1:0]        req_addr,
  output logic [LW-1:0]        req_elem,
  output logic [LW-1:0]        req_pidx,
  output logic                 busy,
  output logic                 done
);

  localparam logic [1:0] M_STRIDE = 2'd0;
  localparam logic [1:0] M_INDEX  = 2'd1;
  localparam logic [1:0] M_COMP   = 2'd2;
  localparam logic [1:0] M_MASK   = 2'd3;

  logic [1:0]          mode_q;
  logic [AW-1:0]       base_q, stride_q;
  logic [LW-1:0]       vl_q, i_q, k_q;
  logic [MAXVL-1:0]    mask_q;
  logic [MAXVL*OW-1:0] off_q;

  logic [LW-1:0] cand;
  logic          found, more;
  logic [OW-1:0] off_e;

  wire           comp  = (mode_q == M_COMP);
  wire [LW-1:0]  vl_in = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
  wire [LW:0]    cnt   = (mode_q == M_MASK) ? (({1'b0, vl_q} + (LW+1)'(7)) >> 3) : {1'b0, vl_q};

  always_comb begin
    cand  = i_q;
    found = 1'b0;
    off_e = '0;
    if (comp) begin
      for (int j = 0; j < MAXVL; j++)
        if (!found && LW'(j) >= i_q && LW'(j) < vl_q && mask_q[j]) begin
          cand  = LW'(j);
          found = 1'b1;
        end
    end
    for (int j = 0; j < MAXVL; j++)
      if (cand == LW'(j)) off_e = off_q[j*OW +: OW];
  end

  assign more = comp ? found : ({1'b0, i_q} < cnt);

  wire [LW-1:0] step     = comp ? k_q : cand;
  wire [AW-1:0] addr_str = base_q + ((stride_q * AW'(step)) << 3);
  wire [AW-1:0] addr_idx = base_q + {{(AW-OW){off_e[OW-1]}}, off_e};

  assign req_addr  = (mode_q == M_INDEX) ? addr_idx : addr_str;
  assign req_elem  = cand;
  assign req_pidx  = step;
  assign req_valid = busy && more;
  assign done      = busy && !more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_q   <= M_STRIDE;
      base_q   <= '0;
      stride_q <= '0;
      vl_q     <= '0;
      mask_q   <= '0;
      off_q    <= '0;
      i_q      <= '0;
      k_q      <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        mode_q   <= mode;
        base_q   <= base;
        stride_q <= stride;
        vl_q     <= vl_in;
        mask_q   <= mask;
        off_q    <= offsets;
        i_q      <= '0;
        k_q      <= '0;
      end
    end else if (!more) begin
      busy <= 1'b0;
    end else if (req_ready) begin
      i_q <= LW'(cand + 1'b1);
      if (comp) k_q <= LW'(k_q + 1'b1);
    end
  end

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(base_q) && $stable(mode_q) && $stable(vl_q));

  assert_comp_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && comp |-> |(mask_q & (MAXVL'(1) << req_elem)));

  assert_comp_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && comp) ##1 req_valid |-> req_pidx == LW'($past(req_pidx) + 1'b1));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_elem) && $stable(req_pidx));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_elem > $past(req_elem)));

endmodule

// File: tb/tb_vec_addr_gen.sv
module tb_vec_addr_gen;
  localparam int AW = 32, OW = 16, MAXVL = 16, LW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_ready = 1'b0;
  logic [1:0] mode = '0;
  logic [AW-1:0] base = '0, stride = '0;
  logic [LW-1:0] vlen = '0;
  logic [MAXVL*OW-1:0] offsets = '0;
  logic [MAXVL-1:0] mask = '0;
  logic req_valid, busy, done;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_elem, req_pidx;

  vec_addr_gen #(.AW(AW), .OW(OW), .MAXVL(MAXVL), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base), .stride(stride),
    .vlen(vlen), .offsets(offsets), .mask(mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_elem(req_elem), .req_pidx(req_pidx), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [AW-1:0] ea [MAXVL];
  int ee [MAXVL], ep [MAXVL];
  int ecount;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string mreq(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic build_exp();
    int vl, k;
    logic [OW-1:0] o;
    vl = (vlen > MAXVL) ? MAXVL : int'(vlen);
    ecount = 0;
    case (mode)
      2'd0: for (int i = 0; i < vl; i++) begin
        ea[i] = base + AW'(i) * stride * AW'(8); ee[i] = i; ep[i] = i; ecount++;
      end
      2'd1: for (int i = 0; i < vl; i++) begin
        o = offsets[i*OW +: OW];
        ea[i] = base + {{(AW-OW){o[OW-1]}}, o}; ee[i] = i; ep[i] = i; ecount++;
      end
      2'd2: begin
        k = 0;
        for (int i = 0; i < vl; i++) if (mask[i]) begin
          ea[k] = base + AW'(k) * stride * AW'(8); ee[k] = i; ep[k] = k; k++;
        end
        ecount = k;
      end
      default: for (int j = 0; j < (vl + 7) / 8; j++) begin
        ea[j] = base + AW'(j) * stride * AW'(8); ee[j] = j; ep[j] = j; ecount++;
      end
    endcase
  endtask

  task automatic run_case(input bit stall, input bit poke);
    int cyc, n, last_acc, exp_done;
    bit prev_stall, rdy;
    logic [AW-1:0] p_addr, sv_base;
    logic [LW-1:0] p_elem, p_pidx;
    logic [1:0] sv_mode;
    string rq;
    build_exp();
    rq = mreq(mode);
    sv_base = base; sv_mode = mode;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0; n = 0; last_acc = -1; prev_stall = 0;
    p_addr = '0; p_elem = '0; p_pidx = '0;
    forever begin
      if (req_valid) begin
        if (n < ecount) begin
          chk(req_addr == ea[n], rq, "address", req_addr, ea[n]);
          chk(int'(req_elem) == ee[n], rq, "element index", req_elem, ee[n]);
          chk(int'(req_pidx) == ep[n], rq, "packed index", req_pidx, ep[n]);
        end else chk(0, "R7", "extra request count", n, ecount);
        if (prev_stall)
          chk(req_addr == p_addr && req_elem == p_elem && req_pidx == p_pidx,
              "R8", "hold under stall", req_addr, p_addr);
      end else if (prev_stall) chk(0, "R8", "valid dropped under stall", 0, 1);
      if (done) begin
        chk(n == ecount, rq, "requests before done", n, ecount);
        exp_done = (ecount == 0) ? 0 : last_acc + 1;
        chk(cyc == exp_done, "R9", "done cycle", cyc, exp_done);
        if (!stall)
          chk(cyc == ecount, "R10", "back-to-back cycles", cyc, ecount);
        break;
      end
      if (cyc > 200) begin chk(0, "R9", "no done", cyc, 0); break; end
      rdy = stall ? ((cyc % 3) != 1) : 1'b1;
      req_ready = rdy;
      if (poke && cyc == 1) begin
        start = 1'b1; base = base ^ 32'h0000_1000; mode = mode ^ 2'd1;
      end
      if (poke && cyc == 2) begin
        start = 1'b0; base = sv_base; mode = sv_mode;
      end
      if (req_valid && rdy) begin last_acc = cyc; n++; end
      prev_stall = req_valid && !rdy;
      p_addr = req_addr; p_elem = req_elem; p_pidx = req_pidx;
      @(negedge clk); cyc++;
    end
    start = 1'b0; base = sv_base; mode = sv_mode;
    @(negedge clk);
    chk(!done && !busy && !req_valid, "R9", "idle after done", {done, busy, req_valid}, 0);
    if (poke) chk(n == ecount, "R2", "start while busy ignored", n, ecount);
  endtask

  initial begin
    #(20ns * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid && !done && !busy, "R1", "reset outputs", {req_valid, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !done && !busy, "R1", "idle after reset", {req_valid, done, busy}, 0);

    for (int s = 0; s < 3; s++)
      for (int v = 0; v <= 18; v++) begin
        mode = 2'd0; vlen = LW'(v); base = 32'h0000_1000 + AW'(v * 4);
        stride = (s == 0) ? 32'd1 : (s == 1) ? 32'd3 : 32'hFFFF_FFFE;
        run_case(v[0], 1'b0);
      end

    for (int i = 0; i < MAXVL; i++)
      offsets[i*OW +: OW] = OW'((i * 16'h1357) ^ ((i & 1) << 15));
    for (int v = 1; v <= 17; v++) begin
      mode = 2'd1; vlen = LW'(v); base = 32'h0004_0000 + AW'(v);
      run_case(v[1], 1'b0);
    end

    for (int t = 0; t < 40; t++) begin
      mode = 2'd2; base = 32'h0008_0000; stride = AW'(1 + t % 3);
      vlen = (t == 5) ? LW'(0) : LW'(1 + t % 17);
      mask = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : 16'(t * 16'h9E37 ^ (t << 7));
      if (t == 2) begin mask = 16'h8001; vlen = LW'(16); end
      run_case(t[0], 1'b0);
    end

    for (int v = 0; v <= 17; v++) begin
      mode = 2'd3; vlen = LW'(v); base = 32'h000C_0000; stride = 32'd2;
      run_case(v[0], 1'b0);
    end

    mode = 2'd0; vlen = LW'(12); base = 32'h0010_0000; stride = 32'd5;
    run_case(1'b1, 1'b1);
    mode = 2'd2; vlen = LW'(16); mask = 16'hA5C3; stride = 32'd1;
    run_case(1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule